// File: doc/BRIEF.md
# Power-Up Hold-Off and Overflow Monitor

This block sits on the digital output side of a four-channel converter and sets what reaches the serial formatter while the device goes into and out of power-down. When the power-down line is low, it forces every sample slot to zero and holds the overflow flag low. It also tracks the role select and the high-pass enable, so that it can capture them at release.

After release, the block counts rising edges of the frame clock. It keeps every sample at zero until the start-up window has ended. The window is 516 edges in master role and 517 in slave role. The overflow flag is kept disabled for the same window.

Once data is released, each frame can be passed through as it is, or its channel pairs can be averaged into mono. Also on each frame, the block compares the magnitude of every channel against a near-full-scale threshold and raises a flag if any channel is above it.

Top module: `pwrup_gate`

## Requirements
- R1: Within one clock after `pdn_i` is sampled low, all four slots of `smp_o` are zero and `ovf_o` is low, and they stay so while `pdn_i` remains low.
- R2: After `pdn_i` rises, the frames whose strobe coincides with the first N frame-clock rising edges produce all-zero output. The first strobed frame after that passes data. N is 516 when `master_i` (1 = master, 0 = slave) was 1 in the last power-down cycle, and 517 when it was 0.
- R3: `ovf_o` stays low throughout the start-up window, whatever the sample values are.
- R4: After the window, a strobed frame sets `ovf_o` to 1 if any channel's two's-complement magnitude is strictly greater than 8,104,000, and to 0 otherwise. A value of -8,388,608 counts as magnitude 8,388,608.
- R5: With `mono_i` = 1, slots 0 and 1 both carry floor((L1+R1)/2), and slots 2 and 3 both carry floor((L2+R2)/2). The sum is formed with one extra bit, so it never wraps. Slot k of a bus occupies bits [24k+23:24k], and the channel order is slot0 = L1, slot1 = R1, slot2 = L2, slot3 = R2.
- R6: With `mono_i` = 0, after the window, each strobed frame is copied slot for slot to `smp_o`, one clock after the strobe.
- R7: `ovf_o` and `smp_o` change only on a strobed frame, or when power-down or start-up forces them low. Between strobes they hold their value.
- R8: `hpf_en_o` takes the value `hpf_en_i` had in the last power-down cycle. Changes to `hpf_en_i` while `pdn_i` is high do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pdn_i | input | 1 | Power-down, active low |
| master_i | input | 1 | Role select: 1 master, 0 slave |
| lrck_i | input | 1 | Frame clock, synchronous to clk_i |
| mono_i | input | 1 | 1 averages channel pairs |
| hpf_en_i | input | 1 | High-pass enable request |
| valid_i | input | 1 | One-cycle strobe, one per frame |
| smp_i | input | 96 | Four 24-bit signed samples |
| smp_o | output | 96 | Gated or averaged samples |
| ovf_o | output | 1 | Overflow flag |
| hpf_en_o | output | 1 | High-pass enable captured at release |

## Verification
The assertions assume three things about the inputs:
- the frame clock is synchronous to the system clock and stays high or low for at least one clock;
- the frame strobe is a single-cycle pulse;
- the role select is only meant to be changed during power-down.

The stimulus drives each frame as a fixed four-clock pattern: the rising frame-clock edge and the strobe fall in the same cycle. It changes the role select and the high-pass enable only around power-down, apart from one deliberate mid-run toggle of the high-pass enable that tests R8.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;
  typedef enum logic {ROLE_SLAVE = 1'b0, ROLE_MASTER = 1'b1} role_e;

  localparam int unsigned SMP_W = 24;

  // two's-complement magnitude; the most negative code maps to 2^(W-1)
  function automatic logic [SMP_W-1:0] smp_mag(input logic [SMP_W-1:0] s);
    return s[SMP_W-1] ? (~s + 1'b1) : s;
  endfunction
endpackage

// File: rtl/pwrup_startup.sv
module pwrup_startup
  import pwrup_pkg::*;
#(
  parameter int unsigned HOLD_MST = 516,
  parameter int unsigned HOLD_SLV = 517
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pdn_i,
  input  logic master_i,
  input  logic lrck_i,
  output logic run_o
);
  localparam int unsigned HOLD_MAX = (HOLD_MST > HOLD_SLV) ? HOLD_MST : HOLD_SLV;
  localparam int unsigned CNT_W    = $clog2(HOLD_MAX + 1);
  localparam logic [CNT_W-1:0] LIM_M = CNT_W'(HOLD_MST);
  localparam logic [CNT_W-1:0] LIM_S = CNT_W'(HOLD_SLV);

  logic             lrck_q;
  logic             rise;
  role_e            role_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             run_q;

  assign rise  = lrck_i & ~lrck_q;
  assign limit = (role_q == ROLE_MASTER) ? LIM_M : LIM_S;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lrck_q <= 1'b0;
    else         lrck_q <= lrck_i;
  end

  // role captured only during power-down
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     role_q <= ROLE_SLAVE;
    else if (!pdn_i) role_q <= role_e'(master_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (!pdn_i) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (!run_q && rise) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == limit - 1'b1) run_q <= 1'b1;
    end
  end

  assign run_o = run_q;

  AST_RUN_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> $past(rise) && $past(pdn_i)); // R2
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= limit); // R2
endmodule

// File: rtl/pwrup_ovf.sv
module pwrup_ovf
  import pwrup_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned THR = 8104000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pdn_i,
  input  logic                 run_i,
  input  logic                 valid_i,
  input  logic [NCH*SMP_W-1:0] smp_i,
  output logic                 ovf_o
);
  localparam logic [SMP_W-1:0] THR_U = SMP_W'(THR);

  logic [NCH-1:0] hit;
  logic           ovf_q;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign hit[k] = smp_mag(smp_i[k*SMP_W +: SMP_W]) > THR_U;
  end

  // evaluated once per strobed frame; disabled in power-down and hold-off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ovf_q <= 1'b0;
    else if (!pdn_i || !run_i)  ovf_q <= 1'b0;
    else if (valid_i)           ovf_q <= |hit;
  end

  assign ovf_o = ovf_q;

  AST_OVF_PER_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ovf_q) |-> $past(valid_i) || !$past(pdn_i) || !$past(run_i)); // R7
endmodule

// File: rtl/pwrup_mono.sv
module pwrup_mono
  import pwrup_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input  logic                 mono_i,
  input  logic [NCH*SMP_W-1:0] smp_i,
  output logic [NCH*SMP_W-1:0] mix_o
);
  localparam int unsigned NPAIR = NCH / 2;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic [SMP_W-1:0] a, b;
    logic [SMP_W:0]   sum;
    assign a   = smp_i[(2*p)*SMP_W +: SMP_W];
    assign b   = smp_i[(2*p+1)*SMP_W +: SMP_W];
    assign sum = {a[SMP_W-1], a} + {b[SMP_W-1], b};
    // arithmetic halve: drop LSB of widened sum
    assign mix_o[(2*p)*SMP_W +: SMP_W]   = mono_i ? sum[SMP_W:1] : a;
    assign mix_o[(2*p+1)*SMP_W +: SMP_W] = mono_i ? sum[SMP_W:1] : b;
  end
endmodule

// File: rtl/pwrup_gate.sv
module pwrup_gate
  import pwrup_pkg::*;
#(
  parameter int unsigned NCH      = 4,
  parameter int unsigned HOLD_MST = 516,
  parameter int unsigned HOLD_SLV = 517,
  parameter int unsigned OVF_THR  = 8104000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pdn_i,
  input  logic                 master_i,
  input  logic                 lrck_i,
  input  logic                 mono_i,
  input  logic                 hpf_en_i,
  input  logic                 valid_i,
  input  logic [NCH*SMP_W-1:0] smp_i,
  output logic [NCH*SMP_W-1:0] smp_o,
  output logic                 ovf_o,
  output logic                 hpf_en_o
);
  localparam int unsigned BUS_W = NCH * SMP_W;

  logic             run;
  logic [BUS_W-1:0] mix;
  logic [BUS_W-1:0] out_q;
  logic             hpf_q;

  pwrup_startup #(.HOLD_MST(HOLD_MST), .HOLD_SLV(HOLD_SLV)) u_start (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pdn_i   (pdn_i),
    .master_i(master_i),
    .lrck_i  (lrck_i),
    .run_o   (run)
  );

  pwrup_mono #(.NCH(NCH)) u_mono (
    .mono_i(mono_i),
    .smp_i (smp_i),
    .mix_o (mix)
  );

  pwrup_ovf #(.NCH(NCH), .THR(OVF_THR)) u_ovf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pdn_i  (pdn_i),
    .run_i  (run),
    .valid_i(valid_i),
    .smp_i  (smp_i),
    .ovf_o  (ovf_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      out_q <= '0;
    else if (!pdn_i)  out_q <= '0;
    else if (valid_i) out_q <= run ? mix : '0;
  end

  // setting frozen outside power-down
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hpf_q <= 1'b0;
    else if (!pdn_i) hpf_q <= hpf_en_i;
  end

  assign smp_o    = out_q;
  assign hpf_en_o = hpf_q;

  AST_PDN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pdn_i |=> (smp_o == '0) && !ovf_o); // R1
  AST_HOLDOFF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> (smp_o == '0)); // R2
  AST_NO_OVF_HOLDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> !ovf_o); // R3
  AST_HPF_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdn_i |=> $stable(hpf_en_o)); // R8
  AST_OUT_PER_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(smp_o) |-> $past(valid_i) || !$past(pdn_i)); // R7
endmodule

// File: tb/sim_pwrup_gate.sv
module sim_pwrup_gate;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pdn_i = 1'b0;
  logic        master_i = 1'b0;
  logic        lrck_i = 1'b0;
  logic        mono_i = 1'b0;
  logic        hpf_en_i = 1'b0;
  logic        valid_i = 1'b0;
  logic [95:0] smp_i = '0;
  logic [95:0] smp_o;
  logic        ovf_o;
  logic        hpf_en_o;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk_i = ~clk_i;

  pwrup_gate u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .pdn_i(pdn_i), .master_i(master_i),
    .lrck_i(lrck_i), .mono_i(mono_i), .hpf_en_i(hpf_en_i), .valid_i(valid_i),
    .smp_i(smp_i), .smp_o(smp_o), .ovf_o(ovf_o), .hpf_en_o(hpf_en_o)
  );

  function automatic logic [23:0] s24(input int v);
    return v[23:0];
  endfunction

  function automatic logic [95:0] pk(input int a, input int b, input int c, input int d);
    return {s24(d), s24(c), s24(b), s24(a)};
  endfunction

  task automatic chk_bus(input string req, input logic [95:0] exp);
    n_chk++;
    if (smp_o !== exp) begin
      n_err++;
      $display("FAIL %s smp_o act=%h exp=%h", req, smp_o, exp);
    end
  endtask

  task automatic chk_bit(input string req, input string nm, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s act=%b exp=%b", req, nm, act, exp);
    end
  endtask

  // one frame: rising frame edge and strobe share a cycle, 4 clocks total
  task automatic frame(input logic [95:0] d);
    @(negedge clk_i); lrck_i = 1'b1; smp_i = d; valid_i = 1'b1;
    @(negedge clk_i); valid_i = 1'b0;
    @(negedge clk_i); lrck_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic power_down(input logic role, input logic hpf);
    @(negedge clk_i); pdn_i = 1'b0; master_i = role; hpf_en_i = hpf;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic t_startup(input logic role, input int n);
    logic [95:0] big;
    int          bad;
    big = pk(8388607, -8388608, 8200000, -8200000);
    bad = 0;
    power_down(role, 1'b1);
    @(negedge clk_i); pdn_i = 1'b1;
    for (int i = 1; i < n; i++) begin
      frame(big);
      if (smp_o !== '0 || ovf_o !== 1'b0) bad++;
    end
    n_chk++;
    if (bad != 0) begin
      n_err++;
      $display("FAIL R2/R3 hold-off frames nonzero count act=%0d exp=0", bad);
    end
    frame(big);
    chk_bus("R2 last hold-off frame", '0);
    chk_bit("R3", "ovf last hold-off frame", ovf_o, 1'b0);
    frame(big);
    chk_bus("R2 first released frame", big);
    chk_bit("R4", "ovf first released frame", ovf_o, 1'b1);
  endtask

  task automatic t_threshold;
    frame(pk(8104000, 0, -8104000, 0));
    chk_bit("R4", "ovf at threshold", ovf_o, 1'b0);
    frame(pk(0, 0, 0, 8104001));
    chk_bit("R4", "ovf threshold+1", ovf_o, 1'b1);
    repeat (10) @(negedge clk_i);
    chk_bit("R7", "ovf held between frames", ovf_o, 1'b1);
    chk_bus("R7 output held between frames", pk(0, 0, 0, 8104001));
    frame(pk(5, -5, 1000, 0));
    chk_bit("R4", "ovf small frame", ovf_o, 1'b0);
    chk_bus("R6 stereo pass", pk(5, -5, 1000, 0));
    frame(pk(0, -8104001, 0, 0));
    chk_bit("R4", "ovf negative beyond", ovf_o, 1'b1);
    frame(pk(0, 0, -8388608, 0));
    chk_bit("R4", "ovf most negative", ovf_o, 1'b1);
  endtask

  task automatic t_mono;
    mono_i = 1'b1;
    frame(pk(100, -300, 8388607, 8388607));
    chk_bus("R5 mono mixed", pk(-100, -100, 8388607, 8388607));
    frame(pk(-8388608, -8388608, 3, 0));
    chk_bus("R5 mono negative full scale and odd", pk(-8388608, -8388608, 1, 1));
    frame(pk(-3, 0, 7, -8));
    chk_bus("R5 mono floor of odd negative", pk(-2, -2, -1, -1));
    mono_i = 1'b0;
    frame(pk(-3, 0, 7, -8));
    chk_bus("R6 stereo after mono", pk(-3, 0, 7, -8));
  endtask

  task automatic t_hpf;
    chk_bit("R8", "hpf latched at release", hpf_en_o, 1'b1);
    @(negedge clk_i); hpf_en_i = 1'b0;
    repeat (5) @(negedge clk_i);
    frame(pk(1, 2, 3, 4));
    chk_bit("R8", "hpf change ignored in operation", hpf_en_o, 1'b1);
  endtask

  task automatic t_pdn_drop;
    frame(pk(8388607, 1, 2, 3));
    chk_bit("R4", "ovf before drop", ovf_o, 1'b1);
    @(negedge clk_i); pdn_i = 1'b0;
    @(negedge clk_i);
    chk_bus("R1 outputs zero after drop", '0);
    chk_bit("R1", "ovf low after drop", ovf_o, 1'b0);
    chk_bit("R8", "hpf follows in power-down", hpf_en_o, 1'b0);
    frame(pk(8388607, 1, 2, 3));
    chk_bus("R1 strobed frame in power-down", '0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_bus("R1 reset state", '0);
    chk_bit("R1", "ovf reset state", ovf_o, 1'b0);
    t_startup(1'b1, 516);
    t_threshold();
    t_mono();
    t_hpf();
    t_pdn_drop();
    t_startup(1'b0, 517);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule